// File: doc/BRIEF.md
# Single-Clock FIFO with Half-Level Flag and Read Rewind

This block is a first-in first-out buffer of 512 words, each 9 bits wide. It generates its read and write addresses internally. A write strobe stores the word on the data input. A read strobe moves the oldest stored word to a registered output. The block has three status flags: empty, full and half. Words leave the buffer in the order they arrived, and all 9 bits pass through unchanged.

A rewind input sets the read position back to the first location written since reset. The words stored since reset can then be read out again, for example to resend a frame after an error on the link. The block uses a single clock and has an active-low asynchronous reset. A read and a write may both be requested in the same cycle.

Top module: `retx_fifo`

## Requirements
- R1: While reset is asserted and immediately after it is released, empty_o is 1, full_o is 0, half_o is 0 and rd_data_o is 0.
- R2: Words are read out in the order they were written, with all 9 data bits unchanged.
- R3: A read request while empty_o is 1 is ignored: rd_data_o and the stored count do not change.
- R4: A write request while full_o is 1 is ignored, unless a read is accepted in the same cycle. In that case the write is accepted.
- R5: full_o is 1 exactly when 512 words are stored, and empty_o is 1 exactly when none are stored.
- R6: half_o is 1 when 257 or more words are stored and 0 when 256 or fewer are stored.
- R7: When a read and a write are both accepted in one cycle, the stored count is unchanged and both positions advance.
- R8: A cycle with rewind_i high sets the read position to the first location and sets the stored count to the number of words written since reset. Any read or write requested in that cycle is ignored. Rewind is only defined while fewer than 512 writes have occurred since reset.
- R9: rd_data_o takes the read word on the clock edge that accepts the read, and holds its value in every other cycle.
- R10: The flags reflect the stored count as it stands after each clock edge, and the count changes by at most one per cycle outside a rewind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 9 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 9 | Registered read data |
| rewind_i | input | 1 | Return the read position to the first location |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | 512 words stored |
| half_o | output | 1 | More than 256 words stored |

## Verification
The bench fills the buffer completely and steps the count across the 256/257 boundary in both directions. A threshold that is off by one would move half_o a cycle early or late. A write at full with a read in the same cycle must be accepted. A design that blocks it would lose a word, and one that always accepts writes at full would overwrite the oldest word. Reads while empty must leave the output register alone, and a design that reads anyway would show stale memory contents. Rewind is exercised with a read and a write requested in the same cycle. A design that lets either one through would produce a wrong count or replay a different word sequence.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } fifo_flags_t;
endpackage

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          rewind_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output fifo_flags_t   flags_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] count_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  assign flags_o.empty = (count_q == '0);
  assign flags_o.full  = (count_q == FULL_CNT);
  assign flags_o.half  = (count_q > HALF_CNT);

  // rewind cycle blocks both ports
  assign rd_ok_o = rd_req_i && !flags_o.empty && !rewind_i;
  assign wr_ok_o = wr_req_i && !rewind_i && (!flags_o.full || rd_ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (rewind_i) begin
      rd_ptr_q <= '0;
      count_q  <= {1'b0, wr_ptr_q};
    end else begin
      if (wr_ok_o) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (rd_ok_o) rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({wr_ok_o, rd_ok_o})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.full && wr_req_i && !rd_req_i && !rewind_i |=> flags_o.full && $stable(wr_ptr_q));
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o.empty && rd_req_i && !wr_req_i && !rewind_i |=> flags_o.empty && $stable(rd_ptr_q));
  assert_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rewind_i |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CW'(1))
                  || (count_q + CW'(1) == $past(count_q)));
  assert_pair_keeps_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o && rd_ok_o |=> $stable(count_q));
  assert_half_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o.half) && !$past(rewind_i) |-> $past(wr_ok_o) && !$past(rd_ok_o));
  assert_rewind_keeps_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> $stable(wr_ptr_q));
endmodule

// File: rtl/retx_fifo_store.sv
module retx_fifo_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_ok_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_ok_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // old word read when full and both ports hit the same slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_ok_i) rd_data_o <= mem_q[rd_addr_i];
  end

  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ok_i |=> $stable(rd_data_o));
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rewind_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o
);
  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;
  fifo_flags_t   flags;

  retx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (wr_en_i),
    .rd_req_i (rd_en_i),
    .rewind_i (rewind_i),
    .wr_ok_o  (wr_ok),
    .rd_ok_o  (rd_ok),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .flags_o  (flags)
  );

  retx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ok_i   (wr_ok),
    .wr_addr_i (wr_ptr),
    .wr_data_i (wr_data_i),
    .rd_ok_i   (rd_ok),
    .rd_addr_i (rd_ptr),
    .rd_data_o (rd_data_o)
  );

  assign empty_o = flags.empty;
  assign full_o  = flags.full;
  assign half_o  = flags.half;

  assert_flags_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && (full_o || half_o)));
  assert_empty_read_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/retx_fifo_bench.sv
module retx_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       empty, full, half;

  int checks = 0;
  int errors = 0;

  logic [8:0] hist[$];
  int         rd_idx = 0;
  logic [8:0] exp_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retx_fifo u_retx_fifo (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rewind_i(rewind),
    .empty_o(empty), .full_o(full), .half_o(half)
  );

  function automatic int cnt();
    return hist.size() - rd_idx;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " rd_data (R2 R9)"}, int'(rd_data), int'(exp_q));
    check({tag, " empty (R5)"}, int'(empty), int'(cnt() == 0));
    check({tag, " full (R5)"}, int'(full), int'(cnt() == DEPTH));
    check({tag, " half (R6)"}, int'(half), int'(cnt() >= 257));
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(string tag, bit w, logic [8:0] d, bit r, bit rw);
    bit ra, wa;
    wr_en = w; wr_data = d; rd_en = r; rewind = rw;
    @(posedge clk);
    ra = r && cnt() > 0 && !rw;
    wa = w && !rw && (cnt() < DEPTH || ra);
    if (ra) begin exp_q = hist[rd_idx]; rd_idx++; end
    if (wa) hist.push_back(d);
    if (rw) rd_idx = 0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    wr_en = 0; rd_en = 0; rewind = 0;
    rst_n = 0;
    hist.delete(); rd_idx = 0; exp_q = '0;
    repeat (2) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step("R3 read empty", 0, 9'h0, 1, 0);
    step("R3 read empty", 0, 9'h0, 1, 0);
    step("R3 read+write empty", 1, 9'h1A5, 1, 0);
    step("R2 read", 0, 9'h0, 1, 0);
    for (int i = 0; i < 10; i++) step("R2 write", 1, 9'(i * 37 + 256), 0, 0);
    for (int i = 0; i < 10; i++) step("R2 read", 0, 9'h0, 1, 0);
    // fill to the half boundary and across it
    for (int i = 0; i < 256; i++) step("R6 fill", 1, 9'($urandom), 0, 0);
    step("R6 to 257", 1, 9'h100, 0, 0);
    step("R6 back to 256", 0, 9'h0, 1, 0);
    step("R6 to 257 again", 1, 9'h0FF, 0, 0);
    step("R7 pair at half", 1, 9'h155, 1, 0);
    for (int i = 0; i < 255; i++) step("R5 fill", 1, 9'($urandom), i % 7 == 0, 0);
    while (cnt() < DEPTH) step("R5 fill", 1, 9'($urandom), 0, 0);
    step("R4 write full", 1, 9'h1FF, 0, 0);
    step("R4 write full", 1, 9'h000, 0, 0);
    step("R4 R7 write+read full", 1, 9'h0AA, 1, 0);
    step("R4 R7 write+read full", 1, 9'h155, 1, 0);
    while (cnt() > 0) step("R2 drain", 0, 9'h0, 1, 0);
    step("R3 read empty", 0, 9'h0, 1, 0);
    // rewind after a fresh reset
    do_reset();
    for (int i = 0; i < 20; i++) step("R8 load", 1, 9'(i + 300), 0, 0);
    for (int i = 0; i < 5; i++) step("R8 read", 0, 9'h0, 1, 0);
    step("R8 rewind with rd+wr", 1, 9'h1EE, 1, 1);
    step("R8 hold", 0, 9'h0, 0, 0);
    for (int i = 0; i < 20; i++) step("R8 replay", 0, 9'h0, 1, 0);
    step("R8 rewind empty", 0, 9'h0, 0, 1);
    for (int i = 0; i < 3; i++) step("R8 R10 replay", 1, 9'(i + 7), 1, 0);
    while (cnt() > 0) step("R8 drain", 0, 9'h0, 1, 0);
    step("R9 idle", 0, 9'h0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule